// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers level-sensitive interrupt request lines in groups of 32 ("banks") and turns them into processor-facing request outputs. Every bank owns a 16-byte register window. The window holds four registers: a read-only view of the live source levels, an enable mask for the normal interrupt output, an independent enable mask for the fast interrupt output, and a third enable mask that drives an endpoint output. Because one set of sources is masked three ways, software can send any source to the normal line, the fast line, the endpoint line, or any mix of them.

Each source input first passes through a two-flop synchronizer. The synchronized level is the cause bit, so nothing is latched and nothing needs to be acknowledged. When a source drops, its cause bit clears. For each bank, a helper output gives the highest-numbered source that is both pending and enabled on the normal line, together with a valid flag. Software can use it to pick what to service first.

Access goes through a plain register bus. A write takes effect on the clock edge where `wr_en_i` is high. A read samples `rd_en_i` and the address on one edge, and the data appears on `rdata_o` from that edge until the next edge. The number of banks is a parameter.

Top module: `banked_intc`

## Requirements
- R1: After reset, all mask registers of every bank read as zero, `irq_o`, `fiq_o`, `endp_o` and every `top_vld_o` bit are low, and `rdata_o` is zero.
- R2: Reading offset 0x00 of a bank returns the source levels as they were two clock edges earlier, bit k holding source k of that bank. When a source line drops, its cause bit clears with the same latency and no write is needed.
- R3: Writes to offset 0x00 change nothing: a later read of the cause still returns the source levels.
- R4: Offset 0x04 is a read/write enable mask for the normal line, where 1 enables a source. `irq_o` is the OR over all banks of cause AND this mask.
- R5: Offset 0x08 is a read/write enable mask for the fast line. `fiq_o` is the OR over all banks of cause AND this mask, independent of the offset 0x04 mask.
- R6: Offset 0x0C is a read/write endpoint mask. `endp_o` is the OR over all banks of cause AND this mask.
- R7: Bank n occupies byte addresses 16n to 16n+15, and global source index 32n+k appears as bit k of bank n.
- R8: `top_idx_o[5n+4:5n]` gives the highest bit position set in bank n's (cause AND offset 0x04 mask), and `top_vld_o[n]` is high exactly when that set is non-empty. When it is empty, the index reads 0.
- R9: Read data is registered. A cycle without a read returns zero. Addresses above the last bank, and addresses whose two low bits are not zero, read as zero and ignore writes.
- R10: Writing zero to a bank's offset 0x04 mask removes every source of that bank from `irq_o` and clears its `top_vld_o` bit on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 32*NUM_BANKS | Level-sensitive source lines; bit 32n+k is source k of bank n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address: bits [ADDR_W-1:4] bank, [3:2] register, [1:0] must be zero |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| endp_o | output | 1 | Endpoint-masked request |
| top_idx_o | output | 5*NUM_BANKS | Highest pending enabled index per bank |
| top_vld_o | output | NUM_BANKS | Per-bank valid flag for `top_idx_o` |

## Verification
A source level change and a mask write can land on the same or adjacent edges. In that case, the request outputs must follow whichever input changed last. The bench provokes this by raising a source line and watching `irq_o` stay low for one edge and rise on the second. It also clears a mask while the sources stay high, then checks that the output and the per-bank valid flag both drop on the edge of the write. Reads of the cause taken right after a write to the cause offset are also judged, so the source view is shown to be unaffected by bus traffic.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_PER_BANK = 32;
  localparam int IDX_W        = $clog2(SRC_PER_BANK);
  localparam int DATA_W       = 32;
  localparam int WIN_LSB      = 4;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_IRQM  = 2'd1,
    SEL_FIQM  = 2'd2,
    SEL_ENDM  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [SRC_PER_BANK-1:0] cause_i,
  input  logic                    wr_en_i,
  input  reg_sel_e                wsel_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       irqm_o,
  output logic [DATA_W-1:0]       fiqm_o,
  output logic [DATA_W-1:0]       endm_o,
  output logic                    irq_hit_o,
  output logic                    fiq_hit_o,
  output logic                    endp_hit_o,
  output logic [IDX_W-1:0]        top_idx_o,
  output logic                    top_vld_o
);
  logic [DATA_W-1:0] irqm_q, fiqm_q, endm_q;
  logic [SRC_PER_BANK-1:0] pend_irq;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irqm_q <= '0;
      fiqm_q <= '0;
      endm_q <= '0;
    end else if (wr_en_i) begin
      case (wsel_i)
        SEL_IRQM: irqm_q <= wdata_i;
        SEL_FIQM: fiqm_q <= wdata_i;
        SEL_ENDM: endm_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign pend_irq   = cause_i & irqm_q;
  assign irq_hit_o  = |pend_irq;
  assign fiq_hit_o  = |(cause_i & fiqm_q);
  assign endp_hit_o = |(cause_i & endm_q);

  always_comb begin
    top_idx_o = '0;
    for (int i = 0; i < SRC_PER_BANK; i++) begin
      if (pend_irq[i]) top_idx_o = IDX_W'(i);
    end
  end

  assign top_vld_o = irq_hit_o;
  assign irqm_o    = irqm_q;
  assign fiqm_o    = fiqm_q;
  assign endm_o    = endm_q;
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [NUM_BANKS*32-1:0]       src_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  output logic                          irq_o,
  output logic                          fiq_o,
  output logic                          endp_o,
  output logic [NUM_BANKS*5-1:0]        top_idx_o,
  output logic [NUM_BANKS-1:0]          top_vld_o
);
  localparam int SRC_TOTAL = NUM_BANKS * SRC_PER_BANK;
  localparam int BSEL_W    = ADDR_W - WIN_LSB;

  logic [SRC_TOTAL-1:0] cause;
  logic [BSEL_W-1:0]    bank_sel;
  reg_sel_e             reg_sel;
  logic                 aligned;
  logic [DATA_W-1:0]    rd_mux;
  logic [DATA_W-1:0]    rdata_q;

  logic [DATA_W-1:0] irqm [NUM_BANKS];
  logic [DATA_W-1:0] fiqm [NUM_BANKS];
  logic [DATA_W-1:0] endm [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_hits, fiq_hits, endp_hits;

  assign bank_sel = addr_i[ADDR_W-1:WIN_LSB];
  assign reg_sel  = reg_sel_e'(addr_i[WIN_LSB-1:2]);
  assign aligned  = (addr_i[1:0] == 2'b00);

  intc_sync #(.W(SRC_TOTAL)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (src_i),
    .q_o   (cause)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_en_i && aligned && (bank_sel == BSEL_W'(b));

    intc_bank u_bank (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .cause_i    (cause[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .wr_en_i    (bank_wr),
      .wsel_i     (reg_sel),
      .wdata_i    (wdata_i),
      .irqm_o     (irqm[b]),
      .fiqm_o     (fiqm[b]),
      .endm_o     (endm[b]),
      .irq_hit_o  (irq_hits[b]),
      .fiq_hit_o  (fiq_hits[b]),
      .endp_hit_o (endp_hits[b]),
      .top_idx_o  (top_idx_o[b*IDX_W +: IDX_W]),
      .top_vld_o  (top_vld_o[b])
    );
  end

  assign irq_o  = |irq_hits;
  assign fiq_o  = |fiq_hits;
  assign endp_o = |endp_hits;

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (aligned && bank_sel == BSEL_W'(b)) begin
        case (reg_sel)
          SEL_CAUSE: rd_mux = cause[b*SRC_PER_BANK +: SRC_PER_BANK];
          SEL_IRQM:  rd_mux = irqm[b];
          SEL_FIQM:  rd_mux = fiqm[b];
          SEL_ENDM:  rd_mux = endm[b];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd_en_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic [NUM_BANKS*32-1:0] src_i,
  input logic                    rd_en_i,
  input logic [31:0]             rdata_o,
  input logic                    irq_o,
  input logic                    fiq_o,
  input logic                    endp_o,
  input logic [NUM_BANKS-1:0]    top_vld_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!irq_o && !fiq_o && !endp_o && top_vld_o == '0 && rdata_o == '0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rd_en_i) |-> rdata_o == '0);

  // R8
  vld_matches_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|top_vld_o) == irq_o);

  // R4
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $past(|src_i, 2));

  // R5
  fiq_needs_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fiq_o |-> $past(|src_i, 2));

  // R6
  endp_needs_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    endp_o |-> $past(|src_i, 2));
endmodule

bind banked_intc banked_intc_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .src_i     (src_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .endp_o    (endp_o),
  .top_vld_o (top_vld_o)
);

// File: tb/banked_intc_bench.sv
`timescale 1ns/1ps
module banked_intc_bench;
  localparam int NB = 2;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [NB*32-1:0] src;
  logic wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic irq, fiq, endp;
  logic [NB*5-1:0] tidx;
  logic [NB-1:0] tvld;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  banked_intc #(.NUM_BANKS(NB), .ADDR_W(AW)) u_banked_intc (
    .clk_i(clk), .rst_i(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
    .endp_o(endp), .top_idx_o(tidx), .top_vld_o(tvld)
  );

  typedef struct packed {
    logic        bank;
    logic [31:0] src;
    logic [31:0] im;
    logic [31:0] fm;
    logic [31:0] em;
    logic        e_irq;
    logic        e_fiq;
    logic        e_endp;
    logic [4:0]  e_idx;
    logic        e_vld;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1},
    '{1'b0, 32'h8000_0010, 32'h0000_0010, 32'h8000_0000, 32'h0, 1'b1, 1'b1, 1'b0, 5'd4, 1'b1},
    '{1'b1, 32'hF000_0000, 32'h0FFF_FFFF, 32'h0, 32'h1000_0000, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0},
    '{1'b1, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h0000_0004, 32'h0, 1'b1, 1'b1, 1'b0, 5'd31, 1'b1},
    '{1'b0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
    '{1'b0, 32'h0000_0300, 32'h0000_0100, 32'h0, 32'h0000_0200, 1'b1, 1'b0, 1'b1, 5'd8, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [31:0] rv;
    rst = 1'b1; src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 fiq/endp", {30'b0, fiq, endp}, 32'h0);
    check("R1 vld", {30'b0, tvld}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    for (int b = 0; b < NB; b++) begin
      for (int r = 1; r < 4; r++) begin
        bus_rd(AW'(b*16 + r*4), rv);
        check("R1 mask", rv, 32'h0);
      end
    end

    // Vector table: R4 R5 R6 R8 R2
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      int base;
      e = VEC[v];
      base = int'(e.bank) * 16;
      @(negedge clk);
      src = '0;
      src[int'(e.bank)*32 +: 32] = e.src;
      bus_wr(AW'(base + 4), e.im);
      bus_wr(AW'(base + 8), e.fm);
      bus_wr(AW'(base + 12), e.em);
      repeat (2) @(negedge clk);
      check("R4 irq_o", {31'b0, irq}, {31'b0, e.e_irq});
      check("R5 fiq_o", {31'b0, fiq}, {31'b0, e.e_fiq});
      check("R6 endp_o", {31'b0, endp}, {31'b0, e.e_endp});
      check("R8 top_idx", {27'b0, tidx[int'(e.bank)*5 +: 5]}, {27'b0, e.e_idx});
      check("R8 top_vld", {31'b0, tvld[e.bank]}, {31'b0, e.e_vld});
      bus_rd(AW'(base), rv);
      check("R2 cause", rv, e.src);
      bus_rd(AW'(base + 4), rv);
      check("R4 irqm readback", rv, e.im);
      bus_rd(AW'(base + 8), rv);
      check("R5 fiqm readback", rv, e.fm);
      bus_rd(AW'(base + 12), rv);
      check("R6 endm readback", rv, e.em);
    end

    // R2 two-edge latency and level removal without ack
    @(negedge clk);
    src = '0;
    bus_wr(8'h04, 32'h0000_0001);
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h0C, 32'h0);
    repeat (2) @(negedge clk);
    src[0] = 1'b1;
    @(negedge clk);
    check("R2 latency edge1", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R2 latency edge2", {31'b0, irq}, 32'h1);
    src[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 drop no ack", {31'b0, irq}, 32'h0);

    // R3 write to cause ignored
    src[31:0] = 32'h0000_0055;
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, rv);
    check("R3 cause write ignored", rv, 32'h0000_0055);

    // R10 zero mask disables bank
    src[31:0] = 32'hFFFF_FFFF;
    bus_wr(8'h04, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R10 before", {31'b0, irq}, 32'h1);
    bus_wr(8'h04, 32'h0);
    check("R10 irq after zero", {31'b0, irq}, 32'h0);
    check("R10 vld after zero", {31'b0, tvld[0]}, 32'h0);

    // R7 bank layout: global source 37 -> bank1 bit5
    src = '0;
    src[37] = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(8'h10, rv);
    check("R7 bank1 cause", rv, 32'h0000_0020);
    bus_rd(8'h00, rv);
    check("R7 bank0 cause", rv, 32'h0);
    check("R7 top_idx bank1", {27'b0, tidx[9:5]}, 32'd5);
    check("R7 vld", {30'b0, tvld}, 32'h2);

    // R9 out of range and misaligned
    bus_rd(8'h20, rv);
    check("R9 out-of-range read", rv, 32'h0);
    bus_wr(8'h24, 32'hFFFF_FFFF);
    bus_wr(8'h05, 32'hFFFF_FFFF);
    bus_rd(8'h04, rv);
    check("R9 stray writes ignored", rv, 32'h0);
    bus_rd(8'h12, rv);
    check("R9 misaligned read", rv, 32'h0);
    @(negedge clk);
    check("R9 idle rdata", rdata, 32'h0);

    finished = 1'b1;
    report();
  end
endmodule